// File: doc/BRIEF.md
# Serial Memory Target with Two-Byte Pointer

This block is a two-wire serial bus target that behaves like a 4096-byte non-volatile memory. It watches an oversampled clock line and data line, recognises the framing markers, answers to one configurable 7-bit device address, and pulls the data line low through an open-drain enable when it must return a zero. A write message carries the device address with the direction bit clear, then a pointer high byte, then a pointer low byte, then any number of data bytes.

Written bytes are collected in a page-sized holding buffer. They reach the array only after the closing STOP, during a commit window measured in system clock cycles. During that window the target ignores the bus. A read begins with a write message that carries only the pointer, continues with a repeated START that sets the direction bit, and streams bytes from the pointer onward until the controller NACKs.

Top module: `ser_mem_target`

## Requirements
- R1: A START (data falling while clock is high) begins address reception, and a STOP (data rising while clock is high) returns the target to idle with the data line released. Bits are sampled on the clock rising edge, most significant bit first.
- R2: When the upper seven bits of the address byte differ from DEV_ADDR, the target does not acknowledge and leaves the data line released for all later bits until the next START.
- R3: A matching address with bit 0 = 0 is acknowledged, and so are the pointer high byte (its low 4 bits form pointer bits 11:8) and the pointer low byte (pointer bits 7:0) that follow it.
- R4: Each data byte after the pointer bytes is acknowledged and stored at the current pointer. After the STOP the stored bytes can be read back.
- R5: During a write the pointer advances only in its low 5 bits. Bytes beyond the end of a 32-byte page wrap to the start of the same page and never spill into the next page.
- R6: A STOP that follows at least one data byte starts a commit window of COMMIT_CYCLES clocks. Inside that window a matching address is NACKed. A STOP after a message with no data bytes starts no window.
- R7: A repeated START keeps the pointer. A matching address with bit 0 = 1 is acknowledged, and the target then returns the byte at the pointer.
- R8: During a read the pointer increments after each byte and wraps from 4095 to 0.
- R9: When the controller NACKs a read byte, the target releases the data line and drives nothing more until the next START.
- R10: The data-line enable changes only after a detected clock falling edge. It never changes while the clock is high.
- R11: During reset and directly after it, the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The main path is tried with several write-then-read vectors, each at a different pointer, page offset and length. A wrong address would show up as a misplaced or missing byte, and a pointer that does not advance would show up as repeated data. A write that starts two bytes before a page end, followed by reads of both ends of that page and of the next page, separates in-page wrapping from linear spill. A read across address 4095 separates the read wrap from the write wrap. Addressing the target right after a data write and right after a pointer-only write separates a commit window that is correctly started from one that is always or never started. Further clocks after a NACKed read byte or a foreign address show whether the line stays released.

// File: rtl/ser_mem_pkg.sv
// Shared types for the serial memory target.
// Assumes: a single engine instance uses the state encoding below.
package ser_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or after STOP
        ST_ADDR,   // receiving device address byte
        ST_PHI,    // receiving pointer high byte
        ST_PLO,    // receiving pointer low byte
        ST_WDAT,   // receiving data bytes
        ST_RDAT,   // transmitting data bytes
        ST_SKIP    // not addressed; wait for START or STOP
    } smt_state_e;
endpackage

// File: rtl/smt_line_sync.sv
// Brings the asynchronous clock and data line levels into the system clock
// domain and derives the clock edges and the START / STOP markers.
// Assumes: each bus phase lasts well over SYNC_STAGES + 1 system clocks.
module smt_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_p, sda_p;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
            scl_p  <= scl_ff[SYNC_STAGES-1];
            sda_p  <= sda_ff[SYNC_STAGES-1];
        end
    end

    // Edge and marker decode on the synchronized levels
    always_comb begin
        scl_lvl   = scl_ff[SYNC_STAGES-1];
        sda_lvl   = sda_ff[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_p;
        scl_fall  = ~scl_lvl & scl_p;
        start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
        stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
    end
endmodule

// File: rtl/smt_store.sv
// Memory array, page holding buffer and commit timer. Bytes pushed during a
// write land in the buffer. A STOP with at least one buffered byte opens a
// commit window that copies one buffer slot per cycle into the array.
// Assumes: COMMIT_CYCLES >= PAGE_BYTES and no push arrives while busy.
module smt_store #(
    parameter int MEM_BYTES     = 4096,
    parameter int PAGE_BYTES    = 32,
    parameter int COMMIT_CYCLES = 1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [$clog2(MEM_BYTES)-1:0] push_addr,
    input  logic [7:0]                   push_data,
    input  logic                         stop_det,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         busy
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int TW     = $clog2(COMMIT_CYCLES + 1);

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [PG_W-1:0]       page;
    logic [TW-1:0]         tmr;
    logic                  done, commit_we;
    logic [OFF_W-1:0]      cidx;

    always_comb begin
        cidx      = tmr[OFF_W-1:0];
        done      = busy && (tmr == TW'(COMMIT_CYCLES - 1));
        commit_we = busy && (tmr < TW'(PAGE_BYTES)) && mask[cidx];
        rd_data   = mem[rd_addr];
    end

    // One holding slot and its valid flag per page offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && push_addr[OFF_W-1:0] == OFF_W'(g))
                pbuf[g] <= push_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[g] <= 1'b0;
            else if (done)
                mask[g] <= 1'b0;
            else if (push && push_addr[OFF_W-1:0] == OFF_W'(g))
                mask[g] <= 1'b1;
        end
    end

    // Page latch on the first buffered byte, and the commit window timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            busy <= 1'b0;
            tmr  <= '0;
        end else begin
            if (push && mask == '0)
                page <= push_addr[ADDR_W-1:OFF_W];
            if (busy) begin
                tmr  <= done ? '0 : tmr + 1'b1;
                busy <= ~done;
            end else if (stop_det && |mask) begin
                busy <= 1'b1;
                tmr  <= '0;
            end
        end
    end

    // Drain one valid buffer slot per cycle into the array
    always_ff @(posedge clk) begin
        if (commit_we)
            mem[{page, cidx}] <= pbuf[cidx];
    end
endmodule

// File: rtl/smt_engine.sv
// Bit and byte protocol engine: address match, pointer load, data receive
// with acknowledge, and data transmit with controller acknowledge.
// Assumes: the edge and marker strobes are one-cycle pulses from the
// synchronizer; the enable only moves on a clock falling edge.
module smt_engine
    import ser_mem_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         OFF_W    = 5,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [7:0]        push_data,
    output logic              sda_oe
);
    smt_state_e state;
    logic [3:0] cnt;       // 0..7 data bits, 8 byte done, 9 ack bit
    logic [7:0] shreg;
    logic [6:0] txsh;
    logic       rw, mack;

    // Protocol sequencing, registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txsh      <= '0;
            rw        <= 1'b0;
            mack      <= 1'b1;
            ptr       <= '0;
            push      <= 1'b0;
            push_addr <= '0;
            push_data <= '0;
            sda_oe    <= 1'b0;
        end else begin
            push <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (state != ST_IDLE && state != ST_SKIP) begin
                if (scl_rise) begin
                    if (cnt < 4'd8) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end else if (cnt == 4'd9) begin
                        mack <= sda_lvl;
                    end
                end else if (scl_fall) begin
                    if (cnt == 4'd8) begin
                        cnt <= 4'd9;
                        case (state)
                            ST_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR && !busy) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                end else begin
                                    state  <= ST_SKIP;
                                    sda_oe <= 1'b0;
                                end
                            end
                            ST_PHI: begin
                                ptr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
                                sda_oe <= 1'b1;
                            end
                            ST_PLO: begin
                                ptr[7:0] <= shreg;
                                sda_oe   <= 1'b1;
                            end
                            ST_WDAT: begin
                                push      <= 1'b1;
                                push_addr <= ptr;
                                push_data <= shreg;
                                ptr       <= {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + 1'b1};
                                sda_oe    <= 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (cnt == 4'd9) begin
                        cnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (rw) begin
                                    state  <= ST_RDAT;
                                    txsh   <= rd_data[6:0];
                                    sda_oe <= ~rd_data[7];
                                    ptr    <= ptr + 1'b1;
                                end else begin
                                    state  <= ST_PHI;
                                    sda_oe <= 1'b0;
                                end
                            end
                            ST_PHI: begin
                                state  <= ST_PLO;
                                sda_oe <= 1'b0;
                            end
                            ST_PLO: begin
                                state  <= ST_WDAT;
                                sda_oe <= 1'b0;
                            end
                            ST_RDAT: begin
                                if (!mack) begin
                                    txsh   <= rd_data[6:0];
                                    sda_oe <= ~rd_data[7];
                                    ptr    <= ptr + 1'b1;
                                end else begin
                                    state  <= ST_SKIP;
                                    sda_oe <= 1'b0;
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (state == ST_RDAT && cnt != 4'd0) begin
                        txsh   <= {txsh[5:0], 1'b0};
                        sda_oe <= ~txsh[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ser_mem_target.sv
// Top of the serial memory target: synchronizer, protocol engine and
// storage. Assumes: open-drain data line resolved outside; bus clock phases
// much longer than the synchronizer latency.
module ser_mem_target #(
    parameter logic [6:0] DEV_ADDR      = 7'h50,
    parameter int         MEM_BYTES     = 4096,
    parameter int         PAGE_BYTES    = 32,
    parameter int         COMMIT_CYCLES = 1000,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic              start_det, stop_det, busy, push;
    logic [ADDR_W-1:0] ptr, push_addr;
    logic [7:0]        push_data, rd_data;

    smt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smt_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .busy(busy), .rd_data(rd_data), .ptr(ptr), .push(push),
        .push_addr(push_addr), .push_data(push_data), .sda_oe(sda_oe)
    );

    smt_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
                .COMMIT_CYCLES(COMMIT_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
        .push_data(push_data), .stop_det(stop_det), .rd_addr(ptr),
        .rd_data(rd_data), .busy(busy)
    );
endmodule

// File: rtl/smt_checker.sv
// Temporal checks on the serial memory target, attached by bind.
// Assumes: strobes are one-cycle pulses from the synchronizer.
module smt_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_lvl,
    input logic scl_fall,
    input logic stop_det,
    input logic busy
);
    // R10: the enable is raised only in the cycle after a clock falling edge
    p_oe_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R10: the enable holds while the synchronized clock stays high
    p_oe_steady_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R6: nothing is driven during a commit window
    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R6: a commit window opens only on a STOP
    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R1: a STOP leaves the data line released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind ser_mem_target smt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
    .scl_fall(scl_fall), .stop_det(stop_det), .busy(busy)
);

// File: tb/test_ser_mem_target.sv
module test_ser_mem_target;
    localparam logic [6:0] DEV = 7'h50;
    localparam int H = 10;
    localparam int Q = 3;
    localparam int WAIT_COMMIT = 1100;
    // {pointer[11:0], length[7:0], first data byte[7:0]}
    localparam logic [27:0] VEC [5] = '{
        {12'h000, 8'd4, 8'h10},
        {12'h123, 8'd3, 8'h3C},
        {12'h7E0, 8'd5, 8'hC1},
        {12'h040, 8'd1, 8'h55},
        {12'hA5F, 8'd1, 8'h99}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    bit   oe_seen = 1'b0;
    bit   prev_scl = 1'b1;
    bit   prev_oe = 1'b0;
    int   r10_viol = 0;
    logic [7:0] rbuf [8];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    ser_mem_target i_ser_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    // Line monitor: enable activity and changes while the bus clock is high
    always @(negedge clk) begin
        if (sda_oe) oe_seen <= 1'b1;
        if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) r10_viol <= r10_viol + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H/2);
        ack = sda_line; tick(H/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H/2);
            b[i] = sda_line; tick(H/2);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write message: address, pointer high, pointer low, n bytes seed+i, STOP
    task automatic mem_write(input logic [11:0] p, input int n, input logic [7:0] seed,
                             output bit allack);
        logic a;
        allack = 1'b1;
        bus_start();
        send_byte({DEV, 1'b0}, a); if (a) allack = 1'b0;
        send_byte({4'h0, p[11:8]}, a); if (a) allack = 1'b0;
        send_byte(p[7:0], a); if (a) allack = 1'b0;
        for (int i = 0; i < n; i++) begin
            send_byte(seed + 8'(i), a); if (a) allack = 1'b0;
        end
        bus_stop();
    endtask

    // Combined read: pointer write, repeated START, n bytes, last NACKed
    task automatic mem_read(input logic [11:0] p, input int n, output bit allack);
        logic a;
        allack = 1'b1;
        bus_start();
        send_byte({DEV, 1'b0}, a); if (a) allack = 1'b0;
        send_byte({4'h0, p[11:8]}, a); if (a) allack = 1'b0;
        send_byte(p[7:0], a); if (a) allack = 1'b0;
        bus_start();
        send_byte({DEV, 1'b1}, a); if (a) allack = 1'b0;
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n - 1));
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit ok;
        logic a;
        logic [7:0] b;
        logic [11:0] p;
        int n;
        logic [7:0] s;

        // R11: released during and after reset
        tick(3);
        chk(sda_oe == 1'b0, "R11 during reset", sda_oe, 0);
        tick(3);
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R11 after reset", sda_oe, 0);

        // R2: foreign address is not acknowledged and nothing is driven after it
        oe_seen = 1'b0;
        bus_start();
        send_byte({7'h51, 1'b0}, a);
        chk(a == 1'b1, "R2 foreign address NACK", a, 1);
        send_byte(8'h00, a);
        chk(a == 1'b1, "R2 later byte NACK", a, 1);
        bus_stop();
        chk(oe_seen == 1'b0, "R2 line released", oe_seen, 0);

        // Vector table: write, wait for commit, combined read back (R3 R4 R7 R8)
        for (int v = 0; v < 5; v++) begin
            p = VEC[v][27:16];
            n = int'(VEC[v][15:8]);
            s = VEC[v][7:0];
            mem_write(p, n, s, ok);
            chk(ok, "R3 R4 write acknowledged", ok, 1);
            tick(WAIT_COMMIT);
            mem_read(p, n, ok);
            chk(ok, "R7 read address acknowledged", ok, 1);
            for (int i = 0; i < n; i++)
                chk(rbuf[i] == s + 8'(i), "R4 R8 read back data", rbuf[i], s + 8'(i));
        end

        // R5: write across a page end wraps inside the page
        mem_write(12'h03E, 4, 8'hA0, ok);
        tick(WAIT_COMMIT);
        mem_read(12'h03E, 2, ok);
        chk(rbuf[0] == 8'hA0 && rbuf[1] == 8'hA1, "R5 page tail", {rbuf[0], rbuf[1]}, 16'hA0A1);
        mem_read(12'h020, 2, ok);
        chk(rbuf[0] == 8'hA2 && rbuf[1] == 8'hA3, "R5 page head", {rbuf[0], rbuf[1]}, 16'hA2A3);
        mem_read(12'h040, 1, ok);
        chk(rbuf[0] == 8'h55, "R5 next page untouched", rbuf[0], 8'h55);

        // R6: address is NACKed inside the commit window, data still lands
        mem_write(12'h300, 1, 8'h5A, ok);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk(a == 1'b1, "R6 busy NACK", a, 1);
        bus_stop();
        tick(WAIT_COMMIT);
        mem_read(12'h300, 1, ok);
        chk(ok && rbuf[0] == 8'h5A, "R6 committed after window", rbuf[0], 8'h5A);

        // R6: a pointer-only write opens no window
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h03, a);
        send_byte(8'h00, a);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk(a == 1'b0, "R6 no window without data", a, 0);
        bus_stop();

        // R8: read pointer wraps from 4095 to 0
        mem_write(12'hFFF, 1, 8'h77, ok);
        tick(WAIT_COMMIT);
        mem_write(12'h000, 1, 8'h88, ok);
        tick(WAIT_COMMIT);
        mem_read(12'hFFF, 2, ok);
        chk(rbuf[0] == 8'h77 && rbuf[1] == 8'h88, "R8 read wrap", {rbuf[0], rbuf[1]}, 16'h7788);

        // R9: after a NACKed read byte the line stays released
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk(a == 1'b0, "R7 read address ACK", a, 0);
        recv_byte(b, 1'b1);
        chk(b == 8'h88, "R7 first byte at pointer", b, 8'h88);
        oe_seen = 1'b0;
        recv_byte(b, 1'b1);
        chk(b == 8'hFF && oe_seen == 1'b0, "R9 released after NACK", b, 8'hFF);
        bus_stop();

        // R1: idle after STOP, line released
        tick(5);
        chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);

        // R10: enable never changed while clock was high
        chk(r10_viol == 0, "R10 no change while clock high", r10_viol, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule